// File: doc/BRIEF.md
# Reset Cause and Crash-Dump Recorder

This block keeps a record of why the last reset happened and holds two debug snapshots taken when a system reset hits. The reset sequencer gives it one-cycle request strobes for each kind of reset. These are power-on, low-power exit, non-debug-module request, software request and system/lifecycle request. The block turns them into a sticky cause vector. Software clears that vector bit by bit with write-one-to-clear strobes.

Two dump buses, one from the CPU and one from the alert handler, are sampled into capture registers. A capture happens only when a system reset event occurs while that dump's capture enable is armed. The enable disarms itself after one capture, so the first crash after arming is kept. Firmware reads the snapshots one 32-bit word at a time through a dump select and a word index. It learns how many words each dump spans from two constant size attributes. It reads only after the CPU has left reset.

Top module: `reset_cause_recorder`

## Requirements
- R1: While `rstN` is low, and on the cycle after a `porReq` strobe, `cause` reads 5'b00001, `armed` reads 2'b00 and every dump word reads zero.
- R2: Cause bit positions are: bit 0 power-on, bit 1 low-power exit (`lowPwrReq`), bit 2 non-debug-module request (`ndmReq`), bit 3 software request (`swReq`), bit 4 system/lifecycle request (`sysReq`). Each strobe sets its bit on the next clock edge.
- R3: Cause bits stay set until cleared. A 1 on `causeClr[i]` clears bit i at the next edge. A bit that is set and cleared in the same cycle ends up set.
- R4: `porReq` overrides everything else in the same cycle: other strobes, arming, clearing and capture. The result is the R1 state.
- R5: A system reset event is any of `lowPwrReq`, `ndmReq`, `swReq` or `sysReq` without `porReq`. When one occurs while `armed[i]` is 1, the dump input present in that cycle is held from the next edge. Index 0 is the CPU dump and index 1 is the alert dump.
- R6: `armSet[i]` sets `armed[i]`. An armed enable clears itself after the event it captured. With `armed[i]` at 0, events leave capture i unchanged.
- R7: An `armSet[i]` in the same cycle as an event does not capture that event, and `armed[i]` reads 1 afterwards.
- R8: `cpuWords` equals ceil(CPU_W/32) and `alertWords` equals ceil(ALERT_W/32).
- R9: `dumpWord` shows word `wordIdx` of the capture chosen by `dumpSel` (0 CPU, 1 alert). Word 0 is bits 31:0. The top word is zero-extended. An index at or above the word count reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset, same effect as power-on |
| porReq | input | 1 | Power-on reset strobe |
| lowPwrReq | input | 1 | Low-power exit reset strobe |
| ndmReq | input | 1 | Non-debug-module reset strobe |
| swReq | input | 1 | Software reset strobe |
| sysReq | input | 1 | System/lifecycle reset strobe |
| cpuDump | input | CPU_W | CPU dump bus |
| alertDump | input | ALERT_W | Alert handler dump bus |
| armSet | input | 2 | Arm capture: bit 0 CPU, bit 1 alert |
| causeClr | input | 5 | Write-one-to-clear strobes for cause bits |
| dumpSel | input | 1 | Dump to read: 0 CPU, 1 alert |
| wordIdx | input | IDX_W | Word index of the dump read |
| cause | output | 5 | Reset cause vector |
| armed | output | 2 | Current capture enables |
| cpuWords | output | IDX_W+1 | CPU dump size in 32-bit words |
| alertWords | output | IDX_W+1 | Alert dump size in 32-bit words |
| dumpWord | output | 32 | Selected dump word |

## Verification
The bench builds the block with CPU_W=40, ALERT_W=70 and IDX_W=3. The CPU dump then has a partial second word, the alert dump has three words with a six-bit top word, and the index space holds several out-of-range values. After every step, all eight indices of both dumps are read, so zero-extension and out-of-range reads are checked on every capture. A random phase mixes strobes, arming and clears, including rare power-on pulses, so same-cycle set/clear and arm/event collisions happen many times.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
  localparam int CAUSE_W = 5;
  localparam int DUMPS = 2;
  typedef struct packed {
    logic             wipe;
    logic [DUMPS-1:0] grab;
  } rcd_strobe_t;
endpackage

// File: rtl/rcd_ctrl.sv
module rcd_ctrl
  import rcd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               porReq,
  input  logic               lowPwrReq,
  input  logic               ndmReq,
  input  logic               swReq,
  input  logic               sysReq,
  input  logic [DUMPS-1:0]   armSet,
  input  logic [CAUSE_W-1:0] causeClr,
  output logic [CAUSE_W-1:0] causeQ,
  output logic [DUMPS-1:0]   armedQ,
  output rcd_strobe_t        strobe
);
  logic [CAUSE_W-1:0] reqBits;
  logic sysEvent;

  assign reqBits  = {sysReq, swReq, ndmReq, lowPwrReq, 1'b0};
  assign sysEvent = |reqBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeQ <= CAUSE_W'(1);
      armedQ <= '0;
    end else if (porReq) begin
      causeQ <= CAUSE_W'(1);
      armedQ <= '0;
    end else begin
      causeQ <= (causeQ & ~causeClr) | reqBits;
      armedQ <= (armedQ & ~{DUMPS{sysEvent}}) | armSet;
    end
  end

  always_comb begin
    strobe.wipe = porReq;
    strobe.grab = (sysEvent && !porReq) ? armedQ : '0;
  end

  p_por_state_r1: assert property (@(posedge clk) disable iff (!rstN)
    porReq |=> (causeQ == CAUSE_W'(1)) && (armedQ == '0));
  p_lowpwr_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (lowPwrReq && !porReq) |=> causeQ[1]);
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!porReq && causeQ[3] && !causeClr[3]) |=> causeQ[3]);
  p_selfclear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!porReq && sysEvent && armedQ[0] && !armSet[0]) |=> !armedQ[0]);
endmodule

// File: rtl/rcd_capture.sv
module rcd_capture #(
  parameter int W     = 64,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wipe,
  input  logic             grab,
  input  logic [W-1:0]     din,
  input  logic [IDX_W-1:0] idx,
  output logic [31:0]      word
);
  localparam int WORDS = (W + 31) / 32;
  localparam int PAD_W = WORDS * 32;

  logic [W-1:0]     store;
  logic [PAD_W-1:0] padded;
  logic [31:0]      wordArr [WORDS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      store <= '0;
    else if (wipe)  store <= '0;
    else if (grab)  store <= din;
  end

  assign padded = PAD_W'(store);

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    assign wordArr[k] = padded[k*32 +: 32];
  end

  always_comb begin
    word = '0;
    for (int k = 0; k < WORDS; k++) begin
      if (idx == IDX_W'(k)) word = wordArr[k];
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!wipe && !grab) |=> $stable(store));
  p_oob_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (int'(idx) >= WORDS) |-> (word == '0));
  p_wipe_r4: assert property (@(posedge clk) disable iff (!rstN)
    wipe |=> (store == '0));
endmodule

// File: rtl/rcd_datapath.sv
module rcd_datapath
  import rcd_pkg::*;
#(
  parameter int CPU_W   = 128,
  parameter int ALERT_W = 256,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  rcd_strobe_t        strobe,
  input  logic [CPU_W-1:0]   cpuDump,
  input  logic [ALERT_W-1:0] alertDump,
  input  logic               dumpSel,
  input  logic [IDX_W-1:0]   wordIdx,
  output logic [31:0]        dumpWord
);
  logic [31:0] cpuWord, alertWord;

  rcd_capture #(.W(CPU_W), .IDX_W(IDX_W)) i_cpuCap (
    .clk(clk), .rstN(rstN), .wipe(strobe.wipe), .grab(strobe.grab[0]),
    .din(cpuDump), .idx(wordIdx), .word(cpuWord));

  rcd_capture #(.W(ALERT_W), .IDX_W(IDX_W)) i_alertCap (
    .clk(clk), .rstN(rstN), .wipe(strobe.wipe), .grab(strobe.grab[1]),
    .din(alertDump), .idx(wordIdx), .word(alertWord));

  assign dumpWord = dumpSel ? alertWord : cpuWord;
endmodule

// File: rtl/reset_cause_recorder.sv
module reset_cause_recorder
  import rcd_pkg::*;
#(
  parameter int CPU_W   = 128,
  parameter int ALERT_W = 256,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               porReq,
  input  logic               lowPwrReq,
  input  logic               ndmReq,
  input  logic               swReq,
  input  logic               sysReq,
  input  logic [CPU_W-1:0]   cpuDump,
  input  logic [ALERT_W-1:0] alertDump,
  input  logic [1:0]         armSet,
  input  logic [4:0]         causeClr,
  input  logic               dumpSel,
  input  logic [IDX_W-1:0]   wordIdx,
  output logic [4:0]         cause,
  output logic [1:0]         armed,
  output logic [IDX_W:0]     cpuWords,
  output logic [IDX_W:0]     alertWords,
  output logic [31:0]        dumpWord
);
  localparam int CPU_WORDS   = (CPU_W + 31) / 32;
  localparam int ALERT_WORDS = (ALERT_W + 31) / 32;

  rcd_strobe_t strobe;

  rcd_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .porReq(porReq), .lowPwrReq(lowPwrReq),
    .ndmReq(ndmReq), .swReq(swReq), .sysReq(sysReq), .armSet(armSet),
    .causeClr(causeClr), .causeQ(cause), .armedQ(armed), .strobe(strobe));

  rcd_datapath #(.CPU_W(CPU_W), .ALERT_W(ALERT_W), .IDX_W(IDX_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuDump(cpuDump),
    .alertDump(alertDump), .dumpSel(dumpSel), .wordIdx(wordIdx),
    .dumpWord(dumpWord));

  assign cpuWords   = (IDX_W+1)'(CPU_WORDS);
  assign alertWords = (IDX_W+1)'(ALERT_WORDS);

  initial begin
    p_idx_fits_r9: assert (CPU_WORDS <= (1 << IDX_W) && ALERT_WORDS <= (1 << IDX_W));
  end
endmodule

// File: tb/test_reset_cause_recorder.sv
module test_reset_cause_recorder;
  localparam int CLK_P = 10;
  localparam int CW = 40;
  localparam int AW = 70;
  localparam int IW = 3;

  logic clk = 0, rstN = 0;
  logic porReq = 0, lowPwrReq = 0, ndmReq = 0, swReq = 0, sysReq = 0;
  logic [CW-1:0] cpuDump = '0;
  logic [AW-1:0] alertDump = '0;
  logic [1:0] armSet = '0;
  logic [4:0] causeClr = '0;
  logic dumpSel = 0;
  logic [IW-1:0] wordIdx = '0;
  logic [4:0] cause;
  logic [1:0] armed;
  logic [IW:0] cpuWords, alertWords;
  logic [31:0] dumpWord;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [4:0] expCause;
  logic [1:0] expArm;
  logic [CW-1:0] expCpu;
  logic [AW-1:0] expAlert;

  reset_cause_recorder #(.CPU_W(CW), .ALERT_W(AW), .IDX_W(IW)) i_reset_cause_recorder (
    .clk(clk), .rstN(rstN), .porReq(porReq), .lowPwrReq(lowPwrReq), .ndmReq(ndmReq),
    .swReq(swReq), .sysReq(sysReq), .cpuDump(cpuDump), .alertDump(alertDump),
    .armSet(armSet), .causeClr(causeClr), .dumpSel(dumpSel), .wordIdx(wordIdx),
    .cause(cause), .armed(armed), .cpuWords(cpuWords), .alertWords(alertWords),
    .dumpWord(dumpWord));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input logic [127:0] v, input int nWords, input int idx);
    if (idx >= nWords) return 32'h0;
    return 32'(v >> (32 * idx));
  endfunction

  task automatic checkAll(input string req);
    chk(req, 32'(cause), 32'(expCause));
    chk(req, 32'(armed), 32'(expArm));
    chk("R8", 32'(cpuWords), (CW + 31) / 32);
    chk("R8", 32'(alertWords), (AW + 31) / 32);
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < (1 << IW); i++) begin
        dumpSel = s[0];
        wordIdx = IW'(i);
        #1;
        if (s == 0) chk("R9", dumpWord, expWord(128'(expCpu), (CW + 31) / 32, i));
        else        chk("R9", dumpWord, expWord(128'(expAlert), (AW + 31) / 32, i));
      end
    end
  endtask

  // Apply one cycle of stimulus starting at a falling edge; check at the next falling edge.
  task automatic step(input logic por, input logic lp, input logic ndm, input logic sw,
                      input logic sys, input logic [1:0] arm, input logic [4:0] clr,
                      input string req);
    logic ev;
    porReq = por; lowPwrReq = lp; ndmReq = ndm; swReq = sw; sysReq = sys;
    armSet = arm; causeClr = clr;
    cpuDump = {$urandom, $urandom};
    alertDump = {$urandom, $urandom, $urandom};
    @(posedge clk);
    ev = lp | ndm | sw | sys;
    if (por) begin
      expCause = 5'b00001; expArm = 2'b00; expCpu = '0; expAlert = '0;
    end else begin
      if (ev && expArm[0]) expCpu = cpuDump;
      if (ev && expArm[1]) expAlert = alertDump;
      expArm = (expArm & ~{ev, ev}) | arm;
      expCause = (expCause & ~clr) | {sys, sw, ndm, lp, 1'b0};
    end
    @(negedge clk);
    porReq = 0; lowPwrReq = 0; ndmReq = 0; swReq = 0; sysReq = 0;
    armSet = '0; causeClr = '0;
    checkAll(req);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    expCause = 5'b00001; expArm = '0; expCpu = '0; expAlert = '0;
    #(CLK_P * 2);
    checkAll("R1");
    @(negedge clk); rstN = 1;
    @(negedge clk);
    checkAll("R1");
    // R2: each strobe sets its own bit; R3: bits accumulate
    step(0, 1, 0, 0, 0, 2'b00, 5'b00000, "R2");
    step(0, 0, 1, 0, 0, 2'b00, 5'b00000, "R2");
    step(0, 0, 0, 1, 0, 2'b00, 5'b00000, "R2");
    step(0, 0, 0, 0, 1, 2'b00, 5'b00000, "R3");
    chk("R3", 32'(cause), 32'h1f);
    // R3: clear, and set-over-clear
    step(0, 0, 0, 0, 0, 2'b00, 5'b11110, "R3");
    chk("R3", 32'(cause), 32'h01);
    step(0, 0, 0, 1, 0, 2'b00, 5'b01001, "R3");
    chk("R3", 32'(cause), 32'h08);
    // R6: arm CPU only, then capture, then no further capture
    step(0, 0, 0, 0, 0, 2'b01, 5'b00000, "R6");
    step(0, 0, 0, 1, 0, 2'b00, 5'b00000, "R5");
    chk("R6", 32'(armed), 32'h0);
    step(0, 0, 0, 1, 0, 2'b00, 5'b00000, "R6");
    // R7: arm in same cycle as event
    step(0, 0, 0, 0, 1, 2'b11, 5'b00000, "R7");
    chk("R7", 32'(armed), 32'h3);
    step(0, 1, 0, 0, 0, 2'b00, 5'b00000, "R5");
    // R4: power-on beats everything
    step(0, 0, 0, 0, 0, 2'b11, 5'b00000, "R4");
    step(1, 1, 1, 1, 1, 2'b11, 5'b11111, "R4");
    chk("R4", 32'(cause), 32'h01);
    // mixed random phase
    for (int n = 0; n < 600; n++) begin
      step(($urandom % 32) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
           ($urandom % 4) == 0, ($urandom % 4) == 0, 2'($urandom % 4),
           5'($urandom & $urandom), "R5");
    end
    // R1: asynchronous reset mid-run
    step(0, 0, 0, 0, 0, 2'b11, 5'b00000, "R6");
    step(0, 0, 1, 0, 0, 2'b00, 5'b00000, "R5");
    #2 rstN = 0;
    #1;
    expCause = 5'b00001; expArm = '0; expCpu = '0; expAlert = '0;
    checkAll("R1");
    @(negedge clk); rstN = 1;
    @(negedge clk);
    checkAll("R1");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule